// File: doc/BRIEF.md
# Masked Event Interrupt Register Set

This block gathers sixteen single-cycle event pulses into a sticky status register. It combines that register with a mask to drive one level-sensitive interrupt line. Typical sources are completion and failure events from a fuse programming and readout engine, plus error and parity events from its cache path. Software sees four 32-bit words on a simple register port.

The four words are:
- a write-one-to-clear status word;
- a read-only mask word;
- an enable word that unmasks sources;
- a disable word that masks sources.

Software cannot write the mask directly. It changes the mask only through the enable and disable words. Those two words are write-only, and they always read back as zero.

Only bit 31 and bits 14 down to 0 are implemented:
- Source k, for k from 0 to 14, lives at bit k.
- Source 15 lives at bit 31.
- Bits 30 to 15 are reserved. They ignore writes and read as zero.

The interrupt output is asserted while any status bit is set and its mask bit is clear.

The port uses a register window. Writes are taken on a clock edge when `bus_wr` is high. Reads return data combinationally for the address on `bus_addr`.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset the status word reads 0x00000000, the mask word reads 0x80007FFF and `irq_out` is low.
- R2: Event source k (0 to 14) maps to bit k and source 15 maps to bit 31 in the status, mask, enable and disable words; bits 30:15 read as 0 and writing 1s to them changes nothing.
- R3: A high `evt_pulse[k]` sampled on a clock edge sets the matching status bit at that edge, whatever the mask holds.
- R4: A write to offset 0x30 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R5: When an event pulse and a clearing write hit the same status bit on the same edge, the bit stays set.
- R6: A write to the mask word at offset 0x34 leaves the mask unchanged.
- R7: A write to offset 0x38 clears each mask bit whose write-data bit is 1; reading offset 0x38 returns 0.
- R8: A write to offset 0x3C sets each mask bit whose write-data bit is 1; reading offset 0x3C returns 0.
- R9: `irq_out` is high exactly when some status bit is 1 while its mask bit is 0, and it reflects a status, enable or disable write, or an event, from the edge that took it.
- R10: A write to any address other than the four word-aligned offsets 0x30, 0x34, 0x38 and 0x3C has no effect, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register for a read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_pulse | input | 16 | One bit per event source, a high level sets its status bit |
| irq_out | output | 1 | Level interrupt, status AND NOT mask reduced by OR |

## Verification
Two kinds of internal error show up in different places:
- A status or mask bit stored at the wrong place, or lost, shows at `bus_rdata` on the very next read of 0x30 or 0x34. It also shows on `irq_out` from the edge that caused it, once the matching source is unmasked.
- A wrong clear priority or a leaking reserved bit shows only when both stimuli meet in one cycle. Each such collision is therefore driven on a single edge and read back at once.

The mask cannot be written directly, so any corruption of it through the write port shows as a changed 0x34 readback immediately after the offending write.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Register word selected inside the four-word window
    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_MASK    = 2'd1,
        SEL_ENABLE  = 2'd2,
        SEL_DISABLE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
    import evt_irq_pkg::*;
#(
    parameter int unsigned          ADDR_W = 8,
    parameter logic [ADDR_W-1:0]    BASE   = 8'h30
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic              hit_o,
    output reg_sel_e          sel_o,
    output logic              wr_status_o,
    output logic              wr_enable_o,
    output logic              wr_disable_o
);
    // Window is four 32-bit words, aligned to 16 bytes
    localparam int unsigned WIN_LSB = 4;

    always_comb begin
        hit_o = (addr_i[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB])
                && (addr_i[1:0] == 2'b00);
        sel_o = reg_sel_e'(addr_i[3:2]);
    end

    always_comb begin
        wr_status_o  = 1'b0;
        wr_enable_o  = 1'b0;
        wr_disable_o = 1'b0;
        if (wr_i && hit_o) begin
            unique case (sel_o)
                SEL_STATUS:  wr_status_o  = 1'b1;
                SEL_MASK:    ; // mask is read-only from the port (R6)
                SEL_ENABLE:  wr_enable_o  = 1'b1;
                SEL_DISABLE: wr_disable_o = 1'b1;
            endcase
        end
    end

    // At most one register write strobe per cycle
    always_comb begin
        assert_one_strobe_R10: assert ($onehot0({wr_status_o, wr_enable_o, wr_disable_o}));
    end

endmodule

// File: rtl/evt_irq_spread.sv
module evt_irq_spread #(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned NUM_SRC = 16
) (
    input  logic [NUM_SRC-1:0] cmp_i,
    output logic [REG_W-1:0]   wide_o
);
    localparam int unsigned LOW_N = NUM_SRC - 1;

    genvar k;
    generate
        for (k = 0; k < LOW_N; k++) begin : g_low
            assign wide_o[k] = cmp_i[k];
        end
        for (k = LOW_N; k < REG_W - 1; k++) begin : g_rsvd
            assign wide_o[k] = 1'b0;
        end
    endgenerate
    assign wide_o[REG_W-1] = cmp_i[NUM_SRC-1];

endmodule

// File: rtl/evt_irq_gather.sv
module evt_irq_gather #(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned NUM_SRC = 16
) (
    input  logic [REG_W-1:0]   wide_i,
    output logic [NUM_SRC-1:0] cmp_o
);
    localparam int unsigned LOW_N = NUM_SRC - 1;

    genvar k;
    generate
        for (k = 0; k < LOW_N; k++) begin : g_low
            assign cmp_o[k] = wide_i[k];
        end
    endgenerate
    assign cmp_o[NUM_SRC-1] = wide_i[REG_W-1];

    // Reserved positions are dropped here (R2)
    logic unused_rsvd;
    assign unused_rsvd = ^wide_i[REG_W-2:LOW_N];

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_en_i,
    input  logic [NUM_SRC-1:0] clr_bits_i,
    output logic [NUM_SRC-1:0] stat_o
);
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] clr_vec;

    always_comb clr_vec = clr_en_i ? clr_bits_i : '0;

    // Event set is applied after the clear, so an event wins (R5)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | evt_i;
    end

    assign stat_o = stat_q;

    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    assert_no_stray_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0));

    assert_no_stray_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_i)) == '0));

endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr_i,
    input  logic               dis_wr_i,
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [NUM_SRC-1:0] mask_o
);
    logic [NUM_SRC-1:0] mask_q;

    // All sources start masked (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '1;
        else if (en_wr_i)  mask_q <= mask_q & ~bits_i;
        else if (dis_wr_i) mask_q <= mask_q | bits_i;
    end

    assign mask_o = mask_q;

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_wr_i || dis_wr_i) |=> $stable(mask_q));

    assert_en_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> ((mask_q & $past(bits_i)) == '0));

    assert_dis_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr_i |=> ((mask_q & $past(bits_i)) == $past(bits_i)));

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 8,
    parameter int unsigned       REG_W   = 32,
    parameter int unsigned       NUM_SRC = 16,
    parameter logic [ADDR_W-1:0] BASE    = 8'h30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic               irq_out
);
    localparam logic [REG_W-1:0] IMPL_BITS =
        {1'b1, {(REG_W-NUM_SRC){1'b0}}, {(NUM_SRC-1){1'b1}}};

    logic               hit;
    reg_sel_e           sel;
    logic               wr_status, wr_enable, wr_disable;
    logic [NUM_SRC-1:0] wbits, stat, mask;
    logic [REG_W-1:0]   stat_wide, mask_wide;

    evt_irq_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
        .addr_i       (bus_addr),
        .wr_i         (bus_wr),
        .hit_o        (hit),
        .sel_o        (sel),
        .wr_status_o  (wr_status),
        .wr_enable_o  (wr_enable),
        .wr_disable_o (wr_disable)
    );

    evt_irq_gather #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_gather (
        .wide_i (bus_wdata),
        .cmp_o  (wbits)
    );

    evt_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_pulse),
        .clr_en_i   (wr_status),
        .clr_bits_i (wbits),
        .stat_o     (stat)
    );

    evt_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr_i  (wr_enable),
        .dis_wr_i (wr_disable),
        .bits_i   (wbits),
        .mask_o   (mask)
    );

    evt_irq_spread #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_spread_stat (
        .cmp_i  (stat),
        .wide_o (stat_wide)
    );

    evt_irq_spread #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_spread_mask (
        .cmp_i  (mask),
        .wide_o (mask_wide)
    );

    // Read mux: enable and disable words are write-only and read as zero
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_STATUS:  bus_rdata = stat_wide;
                SEL_MASK:    bus_rdata = mask_wide;
                SEL_ENABLE:  bus_rdata = '0;
                SEL_DISABLE: bus_rdata = '0;
            endcase
        end
    end

    // Level interrupt straight from the stored state (R9)
    assign irq_out = |(stat & ~mask);

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_BITS) == '0);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1 || stat == '0) |-> !irq_out);

    assert_ctl_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (sel == SEL_ENABLE || sel == SEL_DISABLE)) |-> (bus_rdata == '0));

    assert_miss_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0));

endmodule

// File: tb/evt_irq_regs_test.sv
module evt_irq_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_pulse = 16'h0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    evt_irq_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [15:0] ev);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_pulse = ev;
        @(posedge clk); #1;
        bus_wr = 1'b0; evt_pulse = 16'h0;
    endtask

    task automatic pulse(input logic [15:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(posedge clk); #1;
        evt_pulse = 16'h0;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 status", 8'h30, 32'h0000_0000);
        expect_reg("R1 mask",   8'h34, 32'h8000_7FFF);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        expect_reg("R7 enable reads 0",  8'h38, 32'h0);
        expect_reg("R8 disable reads 0", 8'h3C, 32'h0);
    endtask

    task automatic t_masked_event;
        pulse(16'h8001);
        check("R3 irq stays low while masked", {31'b0, irq_out}, 32'h0);
        expect_reg("R2 R3 status set while masked", 8'h30, 32'h8000_0001);
    endtask

    task automatic t_enable_and_clear;
        bus_write(8'h38, 32'h0000_0001, 16'h0);
        check("R9 irq after enable", {31'b0, irq_out}, 32'h1);
        expect_reg("R7 mask after enable", 8'h34, 32'h8000_7FFE);
        expect_reg("R7 enable reads 0", 8'h38, 32'h0);
        bus_write(8'h30, 32'h8000_0000, 16'h0);
        expect_reg("R4 partial clear", 8'h30, 32'h0000_0001);
        check("R9 irq held", {31'b0, irq_out}, 32'h1);
        bus_write(8'h30, 32'h0000_0001, 16'h0);
        check("R9 irq drops after clear", {31'b0, irq_out}, 32'h0);
        expect_reg("R4 full clear", 8'h30, 32'h0);
    endtask

    task automatic t_collision;
        bus_write(8'h30, 32'h0000_0008, 16'h0008);
        expect_reg("R5 event wins over clear", 8'h30, 32'h0000_0008);
        check("R9 irq low, bit 3 masked", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_mask_write;
        bus_write(8'h34, 32'h0000_0000, 16'h0);
        expect_reg("R6 direct mask write ignored", 8'h34, 32'h8000_7FFE);
        check("R6 irq unchanged", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_enable_disable;
        bus_write(8'h38, 32'h0000_0008, 16'h0);
        check("R9 irq after unmask bit 3", {31'b0, irq_out}, 32'h1);
        expect_reg("R7 mask bit 3 clear", 8'h34, 32'h8000_7FF6);
        bus_write(8'h3C, 32'h0000_0008, 16'h0);
        check("R9 irq after remask bit 3", {31'b0, irq_out}, 32'h0);
        expect_reg("R8 mask bit 3 set", 8'h34, 32'h8000_7FFE);
        expect_reg("R8 disable reads 0", 8'h3C, 32'h0);
        bus_write(8'h3C, 32'h0000_0001, 16'h0);
        expect_reg("R8 mask all set", 8'h34, 32'h8000_7FFF);
    endtask

    task automatic t_layout;
        bus_write(8'h30, 32'hFFFF_FFFF, 16'h0);
        expect_reg("R4 clear all", 8'h30, 32'h0);
        pulse(16'hFFFF);
        expect_reg("R2 all sources", 8'h30, 32'h8000_7FFF);
        check("R1 R9 irq low when all masked", {31'b0, irq_out}, 32'h0);
        bus_write(8'h38, 32'h7FFF_8000, 16'h0);
        expect_reg("R2 reserved enable bits", 8'h34, 32'h8000_7FFF);
        check("R2 irq after reserved enable", {31'b0, irq_out}, 32'h0);
        bus_write(8'h38, 32'h8000_0000, 16'h0);
        expect_reg("R2 source 15 at bit 31", 8'h34, 32'h0000_7FFF);
        check("R2 R9 irq from bit 31", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_bad_address;
        bus_write(8'h40, 32'hFFFF_FFFF, 16'h0);
        bus_write(8'h31, 32'hFFFF_FFFF, 16'h0);
        bus_write(8'h2C, 32'hFFFF_FFFF, 16'h0);
        expect_reg("R10 status unchanged", 8'h30, 32'h8000_7FFF);
        expect_reg("R10 mask unchanged", 8'h34, 32'h0000_7FFF);
        expect_reg("R10 read 0x40", 8'h40, 32'h0);
        expect_reg("R10 read 0x2C", 8'h2C, 32'h0);
        expect_reg("R10 read misaligned", 8'h31, 32'h0);
    endtask

    task automatic t_event_irq_timing;
        bus_write(8'h30, 32'hFFFF_FFFF, 16'h0);
        check("R9 irq low after clear", {31'b0, irq_out}, 32'h0);
        pulse(16'h8000);
        check("R9 irq on event edge", {31'b0, irq_out}, 32'h1);
        expect_reg("R3 status after event", 8'h30, 32'h8000_0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked_event();
        t_enable_and_clear();
        t_collision();
        t_mask_write();
        t_enable_disable();
        t_layout();
        t_bad_address();
        t_event_irq_timing();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule